// File: doc/BRIEF.md
# Two-Level IO Address Translator

This block sits between DMA masters and system memory and turns each bus address into a physical address. The upper address bits pick one of 64 on-chip first-level entries. Each entry covers a 32 MiB region and points at a second-level table in memory. The middle bits pick one 32-bit second-level entry from that table. The block fetches that entry through a memory read port. A small fully associative cache of recent page translations lets repeated accesses to a page skip the fetch.

Software programs the block through a write-only register port. Through it, software turns translation on or off, picks the size of the translation window, loads the first-level entries, and drops cached translations by 16 KiB granule. The block handles one request at a time. The requester presents an address while `req_ready` is high and gets back a physical address, or a fault, as a one-cycle pulse on `rsp_valid`.

A first-level entry can also be a big-page entry. Such an entry passes the address through unchanged and reports its cached and priority bits as attributes.

Top module: `io_xlate`

## Requirements
- R1: While the translate-enable bit (bit 8 of the register at byte offset 0x100) is clear, an accepted request is answered one cycle later with `rsp_paddr` equal to `req_addr` and no fault. The first-level entries and the window are ignored, and no memory read is made.
- R2: Bits [11:0] of the request address appear unchanged in bits [11:0] of every translated physical address (4 KiB pages).
- R3: The window code sits in bits [1:0] of the register at byte offset 0x14C. Code 0 allows addresses below 2^28, code 1 below 2^31, and code 3 below 2^37. Code 2 allows none. A request outside the window, or at or above 2^31, gets a fault one cycle later with no memory read.
- R4: First-level entry i is written at byte offset 0x2B00 + 4*i and is selected by address bits [30:25]. If its bit 31 is clear and its bit 30 (valid) is clear, the request faults one cycle later with no memory read.
- R5: A first-level entry with bit 31 set is a big page. The request is answered one cycle later with the address passed through, `rsp_cached` equal to entry bit 1, and `rsp_prio` equal to entry bit 0.
- R6: When a valid table entry misses the cache, the block makes exactly one memory read, at (entry bits [27:0] << 12) + 4 * address bits [24:12]. The response comes one cycle after the read data is delivered.
- R7: A fetched second-level word with bit 31 set gives physical address {word[27:0], offset} and `rsp_cached` equal to bit 30. With bit 31 clear the request faults and nothing is cached, so the same page misses again.
- R8: A request whose page is already cached is answered one cycle later from the cache, with no memory read.
- R9: A write of V to byte offset 0x2D00 drops every cached page whose address bits [30:14] equal V[16:0]. Other cached pages stay.
- R10: New translations fill the TLB_N cache slots in round-robin order, starting at slot 0 after reset. Once all slots hold an entry, the oldest fill is replaced.
- R11: `req_ready` is low from the cycle after a missed request is accepted until its response is given.
- R12: A fault response always has `rsp_cached` and `rsp_prio` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 14 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request present |
| req_addr | input | BUS_AW | Bus address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | PHYS_AW | Physical address |
| rsp_cached | output | 1 | Cached attribute |
| rsp_prio | output | 1 | Priority attribute |
| mem_rd_valid | output | 1 | Second-level fetch request pulse |
| mem_rd_addr | output | PHYS_AW | Fetch byte address |
| mem_rd_data_valid | input | 1 | Fetch data returned |
| mem_rd_data | input | 32 | Fetched second-level word |

## Verification
Five kinds of result come one cycle after the accepting edge: pass-through, window faults, first-level faults, big pages and cache hits. A miss is answered one cycle after the memory model delivers data. With the model's fixed two-cycle delay, that is five cycles after acceptance. The bench counts falling edges from the accept edge to the `rsp_valid` pulse and compares the count with the latency each case expects. This turns a wrong cache hit or miss into a timing failure. At the first falling edge after a miss is accepted, the bench also samples `req_ready`. It counts and logs memory reads at each rising edge, so it can check the fetch address and confirm that no read happened.

// File: rtl/iat_pkg.sv
package iat_pkg;
  localparam logic [13:0] OFS_CMD    = 14'h0100;
  localparam logic [13:0] OFS_DECODE = 14'h014C;
  localparam logic [13:0] OFS_L1     = 14'h2B00;
  localparam logic [13:0] OFS_INVAL  = 14'h2D00;

  localparam int CMD_EN_BIT   = 8;
  localparam int L1_BIG_BIT   = 31;
  localparam int L1_VALID_BIT = 30;
  localparam int L2_VALID_BIT = 31;
  localparam int L2_CACHE_BIT = 30;
  localparam int PAGE_BITS    = 12;

  typedef enum logic [1:0] {
    WIN_256M = 2'd0,
    WIN_2G   = 2'd1,
    WIN_NONE = 2'd2,
    WIN_128G = 2'd3
  } win_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_st_t;
endpackage

// File: rtl/iat_regs.sv
module iat_regs
  import iat_pkg::*;
#(
  parameter int L1_N   = 64,
  parameter int GRAN_W = 17
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [13:0]               wr_addr,
  input  logic [31:0]               wr_data,
  input  logic [$clog2(L1_N)-1:0]   l1_idx,
  output logic [31:0]               l1_word,
  output logic                      xlate_en,
  output logic [1:0]                win_sel,
  output logic                      inv_en,
  output logic [GRAN_W-1:0]         inv_gran
);
  localparam int IW = $clog2(L1_N);
  localparam logic [13:0] L1_BYTES = 14'(4 * L1_N);

  logic [31:0] l1_q [L1_N];
  logic [13:0] l1_off;
  logic        l1_sel;

  assign l1_off   = wr_addr - OFS_L1;
  assign l1_sel   = wr_en && (l1_off < L1_BYTES);
  assign l1_word  = l1_q[l1_idx];
  assign inv_en   = wr_en && (wr_addr == OFS_INVAL);
  assign inv_gran = wr_data[GRAN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      xlate_en <= 1'b0;
      win_sel  <= 2'd0;
      for (int i = 0; i < L1_N; i++) l1_q[i] <= '0;
    end else begin
      if (wr_en && wr_addr == OFS_CMD)    xlate_en <= wr_data[CMD_EN_BIT];
      if (wr_en && wr_addr == OFS_DECODE) win_sel  <= wr_data[1:0];
      if (l1_sel) l1_q[l1_off[2 +: IW]] <= wr_data;
    end
  end
endmodule

// File: rtl/iat_tlb.sv
module iat_tlb #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 19,
  parameter int RPN_W   = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [RPN_W-1:0]   lk_rpn,
  output logic               lk_cached,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [RPN_W-1:0]   fill_rpn,
  input  logic               fill_cached,
  input  logic               inv_en,
  input  logic [TAG_W-3:0]   inv_gran
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] match;
  logic [RPN_W-1:0]   rpn_w [ENTRIES];
  logic [ENTRIES-1:0] cch_w;
  logic [PW-1:0]      ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             v_q;
    logic             c_q;
    logic [TAG_W-1:0] t_q;
    logic [RPN_W-1:0] r_q;

    assign match[g] = v_q && (t_q == lk_tag);
    assign rpn_w[g] = r_q;
    assign cch_w[g] = c_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        c_q <= 1'b0;
        t_q <= '0;
        r_q <= '0;
      end else if (fill_en && ptr_q == PW'(g)) begin
        v_q <= 1'b1;
        c_q <= fill_cached;
        t_q <= fill_tag;
        r_q <= fill_rpn;
      end else if (inv_en && t_q[TAG_W-1:2] == inv_gran) begin
        v_q <= 1'b0;
      end
    end
  end

  always_comb begin
    lk_hit    = |match;
    lk_rpn    = '0;
    lk_cached = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_rpn    = rpn_w[i];
        lk_cached = cch_w[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (fill_en) ptr_q <= (ptr_q == PW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/io_xlate.sv
module io_xlate
  import iat_pkg::*;
#(
  parameter int BUS_AW  = 40,
  parameter int PHYS_AW = 40,
  parameter int TLB_N   = 4,
  parameter int L1_N    = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic [13:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               req_valid,
  input  logic [BUS_AW-1:0]  req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [PHYS_AW-1:0] rsp_paddr,
  output logic               rsp_cached,
  output logic               rsp_prio,
  output logic               mem_rd_valid,
  output logic [PHYS_AW-1:0] mem_rd_addr,
  input  logic               mem_rd_data_valid,
  input  logic [31:0]        mem_rd_data
);
  localparam int L1_IW   = $clog2(L1_N);
  localparam int L2_IW   = 13;
  localparam int TAG_W   = L1_IW + L2_IW;
  localparam int SPAN_HI = PAGE_BITS + TAG_W;
  localparam int RPN_W   = PHYS_AW - PAGE_BITS;

  walk_st_t                st_q;
  logic                    xlate_en;
  logic [1:0]              win_sel;
  logic                    inv_en;
  logic [TAG_W-3:0]        inv_gran;
  logic [31:0]             l1_word;
  logic [L1_IW-1:0]        l1_idx;
  logic [TAG_W-1:0]        lk_tag;
  logic                    lk_hit;
  logic [RPN_W-1:0]        lk_rpn;
  logic                    lk_cached;
  logic                    fill_en;
  logic [TAG_W-1:0]        sv_tag;
  logic [PAGE_BITS-1:0]    sv_off;
  logic                    accept;
  logic                    out_win;
  logic                    out_span;
  logic                    unused_bits;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign l1_idx    = req_addr[PAGE_BITS + L2_IW +: L1_IW];
  assign lk_tag    = req_addr[PAGE_BITS +: TAG_W];
  assign out_span  = |req_addr[BUS_AW-1:SPAN_HI];
  assign fill_en   = (st_q == ST_WAIT) && mem_rd_data_valid && mem_rd_data[L2_VALID_BIT];
  assign unused_bits = ^{l1_word[29:RPN_W], mem_rd_data[29:RPN_W]};

  always_comb begin
    unique case (win_t'(win_sel))
      WIN_256M: out_win = |req_addr[BUS_AW-1:28];
      WIN_2G:   out_win = |req_addr[BUS_AW-1:31];
      WIN_128G: out_win = |req_addr[BUS_AW-1:37];
      default:  out_win = 1'b1;
    endcase
  end

  iat_regs #(.L1_N(L1_N), .GRAN_W(TAG_W - 2)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .l1_idx   (l1_idx),
    .l1_word  (l1_word),
    .xlate_en (xlate_en),
    .win_sel  (win_sel),
    .inv_en   (inv_en),
    .inv_gran (inv_gran)
  );

  iat_tlb #(.ENTRIES(TLB_N), .TAG_W(TAG_W), .RPN_W(RPN_W)) i_tlb (
    .clk         (clk),
    .rst         (rst),
    .lk_tag      (lk_tag),
    .lk_hit      (lk_hit),
    .lk_rpn      (lk_rpn),
    .lk_cached   (lk_cached),
    .fill_en     (fill_en),
    .fill_tag    (sv_tag),
    .fill_rpn    (mem_rd_data[RPN_W-1:0]),
    .fill_cached (mem_rd_data[L2_CACHE_BIT]),
    .inv_en      (inv_en),
    .inv_gran    (inv_gran)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_cached   <= 1'b0;
      rsp_prio     <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      sv_tag       <= '0;
      sv_off       <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      mem_rd_valid <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (accept) begin
          rsp_fault  <= 1'b0;
          rsp_cached <= 1'b0;
          rsp_prio   <= 1'b0;
          rsp_paddr  <= PHYS_AW'(req_addr);
          if (!xlate_en) begin
            rsp_valid <= 1'b1;
          end else if (out_win || out_span) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
          end else if (l1_word[L1_BIG_BIT]) begin
            rsp_valid  <= 1'b1;
            rsp_cached <= l1_word[1];
            rsp_prio   <= l1_word[0];
          end else if (!l1_word[L1_VALID_BIT]) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
          end else if (lk_hit) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= {lk_rpn, req_addr[PAGE_BITS-1:0]};
            rsp_cached <= lk_cached;
          end else begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= {l1_word[RPN_W-1:0], {PAGE_BITS{1'b0}}}
                            + PHYS_AW'({req_addr[PAGE_BITS +: L2_IW], 2'b00});
            sv_tag <= lk_tag;
            sv_off <= req_addr[PAGE_BITS-1:0];
            st_q   <= ST_WAIT;
          end
        end
      end else if (mem_rd_data_valid) begin
        rsp_valid <= 1'b1;
        st_q      <= ST_IDLE;
        if (mem_rd_data[L2_VALID_BIT]) begin
          rsp_fault  <= 1'b0;
          rsp_paddr  <= {mem_rd_data[RPN_W-1:0], sv_off};
          rsp_cached <= mem_rd_data[L2_CACHE_BIT];
        end else begin
          rsp_fault  <= 1'b1;
          rsp_cached <= 1'b0;
        end
        rsp_prio <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iat_checker.sv
module iat_checker #(
  parameter int BUS_AW  = 40,
  parameter int PHYS_AW = 40
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [BUS_AW-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [PHYS_AW-1:0] rsp_paddr,
  input logic               rsp_cached,
  input logic               rsp_prio,
  input logic               mem_rd_valid,
  input logic [PHYS_AW-1:0] mem_rd_addr,
  input logic               mem_rd_data_valid,
  input logic               xlate_en
);
  p_pass_disabled_r1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_valid && req_ready && !xlate_en))
      |-> (!rsp_fault && rsp_paddr == PHYS_AW'($past(req_addr))));

  p_no_read_disabled_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !xlate_en) |=> !mem_rd_valid);

  p_single_read_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |=> !mem_rd_valid);

  p_read_align_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

  p_busy_walk_r11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  p_rsp_source_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past((req_valid && req_ready) || mem_rd_data_valid));

  p_fault_attr_r12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (!rsp_cached && !rsp_prio));
endmodule

bind io_xlate iat_checker #(.BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW)) i_chk (
  .clk               (clk),
  .rst               (rst),
  .req_valid         (req_valid),
  .req_ready         (req_ready),
  .req_addr          (req_addr),
  .rsp_valid         (rsp_valid),
  .rsp_fault         (rsp_fault),
  .rsp_paddr         (rsp_paddr),
  .rsp_cached        (rsp_cached),
  .rsp_prio          (rsp_prio),
  .mem_rd_valid      (mem_rd_valid),
  .mem_rd_addr       (mem_rd_addr),
  .mem_rd_data_valid (mem_rd_data_valid),
  .xlate_en          (xlate_en)
);

// File: tb/test_io_xlate.sv
module test_io_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;
  localparam int NVEC       = 9;

  // vector: addr[45:6], kind[5:4] (0 table, 1 fault, 2 big page), latency[3:0]
  localparam logic [45:0] VEC [NVEC] = '{
    {40'h00_0000_1234, 2'd0, 4'd5},
    {40'h00_0000_1FFF, 2'd0, 4'd1},
    {40'h00_0200_2000, 2'd0, 4'd5},
    {40'h00_0000_7000, 2'd0, 4'd5},
    {40'h00_0000_7000, 2'd0, 4'd5},
    {40'h00_0400_0000, 2'd1, 4'd1},
    {40'h00_0600_0ABC, 2'd2, 4'd1},
    {40'h00_8000_0000, 2'd1, 4'd1},
    {40'h00_0A00_3000, 2'd0, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [39:0] req_addr = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_fault, rsp_cached, rsp_prio;
  logic [39:0] rsp_paddr;
  logic        mem_rd_valid;
  logic [39:0] mem_rd_addr;
  logic        mem_rd_data_valid;
  logic [31:0] mem_rd_data;

  int n_checks = 0;
  int n_err    = 0;
  int rd_count = 0;
  logic [39:0] last_rd;
  logic [39:0] hold_rd;
  int          lat_cnt;
  bit          done = 0;

  io_xlate i_io_xlate (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_cached(rsp_cached), .rsp_prio(rsp_prio),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [39:0] a);
    logic [31:0] w;
    w[27:0]  = 28'h0050000 + 28'(a[27:2]);
    w[29:28] = 2'b00;
    w[30]    = a[2];
    w[31]    = (a[4:2] != 3'd7);
    return w;
  endfunction

  function automatic logic [27:0] l1_ptr(input int idx);
    case (idx)
      0: return 28'h0000100;
      1: return 28'h0000200;
      5: return 28'h0000300;
      default: return 28'h0;
    endcase
  endfunction

  // memory model: data returns MEM_LAT cycles after the read is seen
  always @(posedge clk) begin
    if (rst) begin
      lat_cnt           <= 0;
      mem_rd_data_valid <= 1'b0;
      mem_rd_data       <= '0;
    end else begin
      mem_rd_data_valid <= 1'b0;
      if (mem_rd_valid) begin
        lat_cnt  <= MEM_LAT;
        hold_rd  <= mem_rd_addr;
        last_rd  <= mem_rd_addr;
        rd_count <= rd_count + 1;
      end else if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin
          mem_rd_data_valid <= 1'b1;
          mem_rd_data       <= mem_word(hold_rd);
        end
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // kind: 0 table model, 1 fault, 2 big page (cached=1 prio=1), 3 plain pass-through
  task automatic run_case(input string tag, input logic [39:0] a,
                          input int kind, input int exp_lat);
    logic [39:0] ma, ep;
    logic [31:0] w;
    logic        ef, ec, eprio;
    int          lat, rd0;
    logic        rdy1;
    ef = 0; ec = 0; eprio = 0; ep = a; ma = '0;
    if (kind == 0) begin
      ma = {l1_ptr(int'(a[30:25])), 12'h000} + 40'({a[24:12], 2'b00});
      w  = mem_word(ma);
      if (w[31]) begin ep = {w[27:0], a[11:0]}; ec = w[30]; end
      else ef = 1;
    end else if (kind == 1) begin
      ef = 1;
    end else if (kind == 2) begin
      ec = 1; eprio = 1;
    end
    @(negedge clk);
    rd0 = rd_count;
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    rdy1 = req_ready;
    lat = 1;
    while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
    check(tag, "latency", 64'(lat), 64'(exp_lat));
    check(ef ? "R12" : tag, "fault", 64'(rsp_fault), 64'(ef));
    if (!ef) check("R2", "paddr", 64'(rsp_paddr), 64'(ep));
    check(ef ? "R12" : tag, "cached", 64'(rsp_cached), 64'(ec));
    check(ef ? "R12" : "R5", "prio", 64'(rsp_prio), 64'(eprio));
    if (exp_lat > 1) begin
      check("R6", "read count", 64'(rd_count - rd0), 64'd1);
      check("R6", "read addr", 64'(last_rd), 64'(ma));
      check("R11", "ready during walk", 64'(rdy1), 64'd0);
    end else begin
      check("R8", "no read", 64'(rd_count - rd0), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    check("R11", "reset ready", 64'(req_ready), 64'd1);
    check("R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R6", "reset mem_rd_valid", 64'(mem_rd_valid), 64'd0);

    // R1: disabled, whole address passes
    run_case("R1", 40'hFF_1234_5678, 3, 1);

    // program first level: R4 entry 2 left invalid, R5 entry 3 big page
    wr(14'h2B00 + 14'd0,  32'h4000_0000 | 32'(l1_ptr(0)));
    wr(14'h2B00 + 14'd4,  32'h4000_0000 | 32'(l1_ptr(1)));
    wr(14'h2B00 + 14'd12, 32'h8000_0003);
    wr(14'h2B00 + 14'd20, 32'h4000_0000 | 32'(l1_ptr(5)));
    wr(14'h014C, 32'h1);
    wr(14'h0100, 32'h100);

    // table walk: R6 R7 R8 R4 R5 R3
    for (int i = 0; i < NVEC; i++) begin
      run_case((VEC[i][5:4] == 2'd1) ? "R4/R3" : (VEC[i][3:0] == 4'd1 ? "R8" : "R7"),
               VEC[i][45:6], int'(VEC[i][5:4]), int'(VEC[i][3:0]));
    end

    // R9: drop granule holding page 0x1000, keep page 0x02002000
    wr(14'h2D00, 32'(40'h1234 >> 14));
    run_case("R9", 40'h00_0000_1234, 0, 5);
    run_case("R9", 40'h00_0200_2000, 0, 1);

    // R3: 256 MiB window
    wr(14'h014C, 32'h0);
    run_case("R3", 40'h00_1000_0000, 1, 1);
    run_case("R3", 40'h00_0A00_3000, 0, 1);

    // R10: round robin, slot 1 (page 0x02002000) is next-but-one victim
    run_case("R10", 40'h00_0000_2000, 0, 5);
    run_case("R10", 40'h00_0000_3000, 0, 5);
    run_case("R10", 40'h00_0A00_3000, 0, 1);
    run_case("R10", 40'h00_0200_2000, 0, 5);

    // R1: disabled ignores invalid first-level entry
    wr(14'h0100, 32'h0);
    run_case("R1", 40'h00_0400_0000, 3, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule